// File: doc/BRIEF.md
# Double-Buffered Serial Transceiver with Internal Loopback

This block is a full-duplex asynchronous serial transceiver for 8-bit characters. Each character is one low start bit, eight data bits sent least significant bit first, and one high stop bit. The host side is a parallel byte port. A put loads a one-character transmit holding register. A get takes the oldest received character from a holding register that sits behind the receive shift register. The ready, empty, overrun and framing flags update on their own when the host puts or gets a byte, so the host never clears a flag by hand.

Timing comes from a shared prescaler. The prescaler produces one sample tick every `baud_div + 1` clocks, and one bit lasts `SAMPLES` ticks. The receiver first confirms a start bit at mid-bit. It then decides each bit by a majority vote of three samples around the middle of the bit. Transmit and receive each have their own enable. A loopback mode routes the serial output of the transmitter internally into the receiver and holds the external pin high, so that software can test the block.

Top module: `serial_xcvr`

## Requirements
- R1: After reset `txd` is 1, `tx_empty` is 1, and `rx_ready`, `overrun` and `frame_err` are 0.
- R2: A transmitted character appears on `txd` as a 0 start bit, then 8 data bits with the LSB first, then a 1 stop bit. Each bit lasts `SAMPLES*(baud_div+1)` clocks, and the line is 1 when no character is being sent.
- R3: A put (`wr_valid` high while `tx_empty` is 1 and `tx_en` is 1) makes `tx_empty` 0 on the next cycle. `tx_empty` returns to 1 when the shifter takes the byte. A put while `tx_empty` is 0 is ignored, and that byte is never sent.
- R4: A character received on `rxd` sets `rx_ready` and appears on `rd_data`. A get (`rd_req` high while `rx_ready` is 1) clears `rx_ready` on the next cycle.
- R5: A low pulse that is not still low at mid-bit is rejected as a false start and delivers no character. The next valid character after it is received correctly.
- R6: When a character completes while `rx_ready` is 1 and no get happens in that cycle, the held byte is kept, the new byte is dropped, and `overrun` is set. A get clears `overrun`.
- R7: A character whose stop bit is sampled as 0 is still delivered, with `frame_err` set to 1. A get clears `frame_err`.
- R8: With `loop_en` at 1, the transmitter feeds the receiver internally, `txd` stays 1, and `rxd` is ignored.
- R9: With `tx_en` at 0, `txd_oe` is 0 and puts are ignored. With `rx_en` at 0, characters on `rxd` are ignored.
- R10: When a get falls in the same cycle as a character completion, the get returns the old byte, the new byte is held with `rx_ready` still 1, and `overrun` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tx_en | input | 1 | Transmitter enable |
| rx_en | input | 1 | Receiver enable |
| loop_en | input | 1 | Internal loopback select |
| baud_div | input | DIV_W | Prescaler divisor minus one; one tick every baud_div+1 clocks |
| wr_valid | input | 1 | Put strobe |
| wr_data | input | 8 | Byte to transmit |
| tx_empty | output | 1 | Transmit holding register free |
| rd_req | input | 1 | Get strobe |
| rd_data | output | 8 | Held received byte |
| rx_ready | output | 1 | Received byte available |
| overrun | output | 1 | A character was dropped because the holding register was full |
| frame_err | output | 1 | Held byte had a low stop bit |
| txd | output | 1 | Serial transmit pin |
| txd_oe | output | 1 | Transmit pin output enable |
| rxd | input | 1 | Serial receive pin |

## Verification
A host get and the completion of the next received character can land in the same clock cycle. In that cycle the holding register is both emptied and refilled. The bench fills the holding register first. It then sends a second character and issues a single-cycle get at each offset of a sweep, one clock apart, across the window where the second stop bit is decided. Each outcome is judged against one rule. The get must return the first byte in every case. Afterwards, either the second byte is held with no overrun, or the holding register is empty with no overrun. Both outcomes must occur somewhere in the sweep.

// File: rtl/serial_xcvr.sv
module serial_xcvr #(
  parameter int SAMPLES = 16,
  parameter int DIV_W   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_en,
  input  logic             rx_en,
  input  logic             loop_en,
  input  logic [DIV_W-1:0] baud_div,
  input  logic             wr_valid,
  input  logic [7:0]       wr_data,
  output logic             tx_empty,
  input  logic             rd_req,
  output logic [7:0]       rd_data,
  output logic             rx_ready,
  output logic             overrun,
  output logic             frame_err,
  output logic             txd,
  output logic             txd_oe,
  input  logic             rxd
);
  localparam int SW  = $clog2(SAMPLES);
  localparam int MID = SAMPLES / 2;

  logic [DIV_W-1:0] pre;
  logic tick;
  assign tick = (pre == baud_div);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pre <= '0;
    else        pre <= tick ? '0 : pre + 1'b1;

  // transmit path
  logic          tx_full, tx_busy;
  logic [7:0]    tx_hold;
  logic [9:0]    tx_sh;
  logic [SW-1:0] tx_sc;
  logic [3:0]    tx_bc;
  logic          put, load, tx_line;

  assign put      = wr_valid && !tx_full && tx_en;
  assign load     = tx_full && !tx_busy && tx_en;
  assign tx_line  = tx_busy ? tx_sh[0] : 1'b1;
  assign txd      = loop_en ? 1'b1 : tx_line;
  assign txd_oe   = tx_en;
  assign tx_empty = !tx_full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      tx_full <= 1'b0; tx_hold <= '0; tx_busy <= 1'b0;
      tx_sh <= '1; tx_sc <= '0; tx_bc <= '0;
    end else begin
      if (put) begin
        tx_full <= 1'b1;
        tx_hold <= wr_data;
      end else if (load) tx_full <= 1'b0;
      if (load) begin
        tx_busy <= 1'b1;
        tx_sh   <= {1'b1, tx_hold, 1'b0};
        tx_sc   <= '0;
        tx_bc   <= '0;
      end else if (tx_busy && tick) begin
        if (tx_sc == SW'(SAMPLES-1)) begin
          tx_sc <= '0;
          tx_sh <= {1'b1, tx_sh[9:1]};
          if (tx_bc == 4'd9) tx_busy <= 1'b0;
          else               tx_bc <= tx_bc + 1'b1;
        end else tx_sc <= tx_sc + 1'b1;
      end
    end

  // receive path
  logic [1:0]    rs;
  logic          rx_s, rx_act, rx_full, ovr, ferr;
  logic [SW-1:0] rx_sc;
  logic [3:0]    rx_bc;
  logic [1:0]    smp;
  logic [7:0]    rx_sh, rx_hold;
  logic          maj, decide, done, get;

  assign rx_s   = rs[1];
  assign maj    = (smp[0] & smp[1]) | (smp[0] & rx_s) | (smp[1] & rx_s);
  assign decide = rx_act && tick && (rx_sc == SW'(MID+1));
  assign done   = decide && (rx_bc == 4'd9);
  assign get    = rd_req && rx_full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rs <= '1;
    else        rs <= {rs[0], loop_en ? tx_line : rxd};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_act <= 1'b0; rx_sc <= '0; rx_bc <= '0; smp <= '1; rx_sh <= '0;
    end else if (!rx_en) rx_act <= 1'b0;
    else if (!rx_act) begin
      if (tick && !rx_s) begin
        rx_act <= 1'b1;
        rx_sc  <= SW'(1);
        rx_bc  <= '0;
      end
    end else if (tick) begin
      if (rx_sc == SW'(MID-1) || rx_sc == SW'(MID)) smp <= {smp[0], rx_s};
      if (decide) begin
        if (rx_bc == 4'd0) begin
          if (maj) rx_act <= 1'b0;
        end else if (rx_bc == 4'd9) rx_act <= 1'b0;
        else rx_sh <= {maj, rx_sh[7:1]};
      end
      if (rx_sc == SW'(SAMPLES-1)) begin
        rx_sc <= '0;
        rx_bc <= rx_bc + 1'b1;
      end else rx_sc <= rx_sc + 1'b1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rx_full <= 1'b0; rx_hold <= '0; ovr <= 1'b0; ferr <= 1'b0;
    end else if (done) begin
      if (rx_full && !get) ovr <= 1'b1;
      else begin
        rx_hold <= rx_sh;
        rx_full <= 1'b1;
        ferr    <= !maj;
        ovr     <= 1'b0;
      end
    end else if (get) begin
      rx_full <= 1'b0;
      ovr     <= 1'b0;
      ferr    <= 1'b0;
    end

  assign rd_data   = rx_hold;
  assign rx_ready  = rx_full;
  assign overrun   = ovr;
  assign frame_err = ferr;

  p_put_fills_r3: assert property (@(posedge clk) disable iff (!rst_n)
    put |=> !tx_empty);
  p_get_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (get && !done) |=> !rx_ready);
  p_hold_kept_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_full && !get) |=> $stable(rd_data));
  p_overrun_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overrun) |-> $past(rx_full));
  p_rx_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> !rx_act);
endmodule

// File: tb/sim_serial_xcvr.sv
module sim_serial_xcvr;
  localparam int P = 16 * 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tx_en = 1'b1, rx_en = 1'b1, loop_en = 1'b0;
  logic [15:0] baud_div = 16'd3;
  logic wr_valid = 1'b0, rd_req = 1'b0, rxd = 1'b1;
  logic [7:0] wr_data = '0;
  logic tx_empty, rx_ready, overrun, frame_err, txd, txd_oe;
  logic [7:0] rd_data;

  int checks = 0, fails = 0, cyc = 0;
  bit finished = 0, mon = 0, low_seen = 0;

  serial_xcvr u0 (.clk, .rst_n, .tx_en, .rx_en, .loop_en, .baud_div,
    .wr_valid, .wr_data, .tx_empty, .rd_req, .rd_data, .rx_ready,
    .overrun, .frame_err, .txd, .txd_oe, .rxd);

  always #5 clk = ~clk;

  always @(negedge clk) begin
    if (mon && !txd) low_seen = 1;
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      fails++;
      $display("FAIL watchdog: act %0d exp <150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act 0x%0h exp 0x%0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [7:0] b);
    @(negedge clk); wr_valid = 1'b1; wr_data = b;
    @(negedge clk); wr_valid = 1'b0;
  endtask

  task automatic get(output logic [7:0] b);
    @(negedge clk); b = rd_data; rd_req = 1'b1;
    @(negedge clk); rd_req = 1'b0;
  endtask

  task automatic send_rx(input logic [7:0] b, input logic stop);
    logic [9:0] f;
    f = {stop, b, 1'b0};
    for (int i = 0; i < 10; i++) begin
      @(negedge clk); rxd = f[i];
      repeat (P - 1) @(negedge clk);
    end
    @(negedge clk); rxd = 1'b1;
  endtask

  task automatic watch_tx(output logic [7:0] b, output logic st, output logic sp);
    while (txd) @(negedge clk);
    repeat (P / 2) @(negedge clk);
    st = txd;
    for (int i = 0; i < 8; i++) begin
      repeat (P) @(negedge clk);
      b[i] = txd;
    end
    repeat (P) @(negedge clk);
    sp = txd;
  endtask

  function automatic bit outcome_ok(input logic rdy, input logic [7:0] d,
                                    input logic ov, input logic [7:0] nb);
    return (rdy && d == nb && !ov) || (!rdy && !ov);
  endfunction

  initial begin
    logic [7:0] a, b, c, got;
    logic st, sp;
    int hit_same, hit_late;
    void'($urandom(32'd20240611));
    hit_same = 0; hit_late = 0;

    repeat (3) @(negedge clk);
    chk(txd == 1, "R1 txd", txd, 1);
    chk(tx_empty == 1, "R1 tx_empty", tx_empty, 1);
    chk(rx_ready == 0, "R1 rx_ready", rx_ready, 0);
    chk(overrun == 0 && frame_err == 0, "R1 flags", {overrun, frame_err}, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R3: one-byte buffer, third put while full is dropped
    a = 8'hA5; b = 8'h3C; c = 8'hFF;
    put(a);
    chk(tx_empty == 0, "R3 empty after put", tx_empty, 0);
    while (!tx_empty) @(negedge clk);
    put(b);
    put(c);
    chk(tx_empty == 0, "R3 put while full", tx_empty, 0);
    watch_tx(got, st, sp);
    chk(got == a && st == 0 && sp == 1, "R2 first frame", got, a);
    watch_tx(got, st, sp);
    chk(got == b && st == 0 && sp == 1, "R3 second frame", got, b);
    low_seen = 0; mon = 1;
    repeat (3 * P) @(negedge clk);
    mon = 0;
    chk(low_seen == 0, "R3 dropped byte not sent", low_seen, 0);
    chk(tx_empty == 1, "R3 empty at end", tx_empty, 1);

    // R2: random transmit bytes
    for (int n = 0; n < 6; n++) begin
      a = 8'($urandom);
      put(a);
      watch_tx(got, st, sp);
      chk(got == a && st == 0 && sp == 1, "R2 tx frame", got, a);
    end

    // R4: random receive bytes
    for (int n = 0; n < 8; n++) begin
      a = 8'($urandom);
      send_rx(a, 1'b1);
      chk(rx_ready == 1, "R4 ready", rx_ready, 1);
      get(got);
      chk(got == a, "R4 data", got, a);
      chk(rx_ready == 0, "R4 cleared by get", rx_ready, 0);
    end

    // R7: framing error
    a = 8'h5A;
    send_rx(a, 1'b0);
    repeat (2 * P) @(negedge clk);
    chk(rx_ready == 1 && frame_err == 1, "R7 frame_err set", {rx_ready, frame_err}, 3);
    get(got);
    chk(got == a, "R7 data", got, a);
    chk(frame_err == 0, "R7 cleared", frame_err, 0);

    // R6: overrun
    a = 8'h11; b = 8'h22;
    send_rx(a, 1'b1);
    send_rx(b, 1'b1);
    chk(overrun == 1 && rx_ready == 1, "R6 overrun set", {overrun, rx_ready}, 3);
    get(got);
    chk(got == a, "R6 held byte kept", got, a);
    chk(overrun == 0 && rx_ready == 0, "R6 cleared", {overrun, rx_ready}, 0);

    // R5: glitch rejected, next frame fine
    @(negedge clk); rxd = 1'b0;
    repeat (3) @(negedge clk); rxd = 1'b1;
    repeat (2 * P) @(negedge clk);
    chk(rx_ready == 0, "R5 glitch rejected", rx_ready, 0);
    a = 8'hC3;
    send_rx(a, 1'b1);
    get(got);
    chk(got == a, "R5 frame after glitch", got, a);

    // R8: loopback
    loop_en = 1'b1; rxd = 1'b0;
    for (int n = 0; n < 4; n++) begin
      a = 8'($urandom);
      low_seen = 0; mon = 1;
      put(a);
      repeat (11 * P + 20) @(negedge clk);
      mon = 0;
      chk(low_seen == 0, "R8 txd idle", low_seen, 0);
      chk(rx_ready == 1, "R8 ready", rx_ready, 1);
      get(got);
      chk(got == a, "R8 looped data", got, a);
    end
    rxd = 1'b1;
    repeat (4) @(negedge clk);
    loop_en = 1'b0;
    repeat (4) @(negedge clk);

    // R9: enables
    tx_en = 1'b0;
    @(negedge clk);
    chk(txd_oe == 0, "R9 oe off", txd_oe, 0);
    put(8'h77);
    chk(tx_empty == 1, "R9 put ignored", tx_empty, 1);
    tx_en = 1'b1;
    low_seen = 0; mon = 1;
    repeat (2 * P) @(negedge clk);
    mon = 0;
    chk(low_seen == 0, "R9 nothing sent", low_seen, 0);
    rx_en = 1'b0;
    send_rx(8'h0F, 1'b1);
    chk(rx_ready == 0, "R9 rx ignored", rx_ready, 0);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);

    // R10: get swept across the completion cycle
    for (int off = 0; off < 24; off++) begin
      a = 8'($urandom); b = ~a;
      send_rx(a, 1'b1);
      fork
        send_rx(b, 1'b1);
        begin
          repeat (604 + off) @(negedge clk);
          got = rd_data; rd_req = 1'b1;
          @(negedge clk); rd_req = 1'b0;
        end
      join
      chk(got == a, "R10 get returns old", got, a);
      chk(outcome_ok(rx_ready, rd_data, overrun, b), "R10 outcome",
          {overrun, rx_ready, rd_data}, {1'b0, 1'b1, b});
      if (rx_ready) begin
        hit_same++;
        get(got);
      end else hit_late++;
    end
    chk(hit_same > 0, "R10 same-cycle outcome seen", hit_same, 1);
    chk(hit_late > 0, "R10 late outcome seen", hit_late, 1);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule